// File: doc/BRIEF.md
# Vector Operand Group Legality Checker

This block screens a vector instruction's operand configuration ahead of issue. It takes the register-grouping field and element-width field of the active vector type, the per-operand width settings, the operand register numbers, the vector length, the start index and an element-group size that the opcode supplies. It works out how many registers each operand spans, as a signed base-2 logarithm. It then decides whether the combination is legal. When it is not, it reports a single cause code.

Every multiplier is handled as a base-2 exponent. An operand either inherits the grouping from the vector type, doubles it when it is the widened destination, or scales it by the ratio of its own width to the selected element width. Element groups add two rules. The length and the start index must be whole multiples of the group size. An operand whose group is wider than one vector register must also be aligned to the number of registers that group covers. Results appear one cycle after a valid request, qualified by a valid output.

Top module: `vop_legal_chk`

## Requirements
- R1: The grouping field decodes 000→1, 001→2, 010→4, 011→8, 111→1/2, 110→1/4, 101→1/8. A used operand that inherits this grouping reports it on its slice of `out_emul_log` as a signed 4-bit log2 value, e.g. 1/4 → -2. Slice i is bits [4i+3:4i], and operand 0 is the destination.
- R2: Grouping field 100 is reserved. It gives illegal with cause 1, and all multiplier slices read 0.
- R3: Width field codes 000/001/010/011 select 8/16/32/64 bits. Codes with the top bit set are reserved and give cause 2 when the grouping field is legal, with all slices 0.
- R4: A used operand with its own-width flag set reports the multiplier EEW×LMUL/SEW. Its width code 0..3 means 8/16/32/64 bits.
- R5: When the widening flag is set, operand 0 (unless it has its own width) reports twice the decoded grouping.
- R6: Any used operand whose multiplier is above 8 or below 1/8 gives cause 3. An element group covering more than 8 registers also gives cause 3.
- R7: A used operand with an integer multiplier of N registers must have a register number that is a multiple of N. Fractional multipliers impose no constraint. A violation gives cause 4.
- R8: With element groups enabled and a group of 2^g elements, both the vector length and the start index must be multiples of 2^g, otherwise cause 5. With groups disabled, both are ignored.
- R9: With element groups enabled, a group of SEW×2^g bits that is wider than VLEN spans SEW×2^g/VLEN registers. Each used operand's register number must be a multiple of that count, otherwise cause 4.
- R10: Operands whose used bit is clear raise no error and report 0.
- R11: When several rules fail, the reported cause is the lowest-numbered one (1 before 2 before 3 before 4 before 5). The illegal flag is set exactly when the cause is nonzero, and a legal request gives cause 0.
- R12: Results are registered in the cycle after `in_valid`, and `out_valid` follows `in_valid` by one cycle. Without `in_valid` the result outputs hold. Reset clears every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_lmul_code | input | 3 | Register-grouping field of the vector type |
| in_sew_code | input | 3 | Selected element width field |
| in_widen | input | 1 | Destination is widened |
| in_op_used | input | NOPS | Operand participates in checks |
| in_op_own_eew | input | NOPS | Operand carries its own element width |
| in_op_eew_code | input | 2*NOPS | Per-operand width code |
| in_op_reg | input | 5*NOPS | Per-operand base register number |
| in_eg_en | input | 1 | Opcode works on element groups |
| in_egs_log | input | 3 | log2 of element-group size |
| in_vl | input | VL_W | Vector length in elements |
| in_vstart | input | VL_W | Start index in elements |
| out_valid | output | 1 | Result valid |
| out_emul_log | output | 4*NOPS | Per-operand signed log2 multiplier |
| out_illegal | output | 1 | Configuration rejected |
| out_cause | output | 3 | Rejection cause |

## Verification
The bench builds the block with its defaults: three operands, 128-bit registers and 16-bit length fields. With a 128-bit register width, group sizes of one to 128 elements at 8 to 64 bits produce groups narrower than, equal to and up to 64 times wider than a register. That covers the single-register, multi-register alignment and out-of-range group cases. The first sweep covers every grouping code, every width code, both widening settings, each own-width code and register numbers 0 to 7. The second sweeps group size, length and start index against the alignment of group-spanning operands.

// File: rtl/vop_legal_pkg.sv
package vop_legal_pkg;

   localparam int REG_W  = 5;
   localparam int EMUL_W = 4;
   localparam int CODE_W = 3;
   localparam int EEWC_W = 2;

   typedef enum logic [2:0] {
      CAUSE_NONE  = 3'd0,
      CAUSE_VLMUL = 3'd1,
      CAUSE_SEW   = 3'd2,
      CAUSE_EMUL  = 3'd3,
      CAUSE_ALIGN = 3'd4,
      CAUSE_EGRP  = 3'd5
   } vop_cause_e;

   typedef logic signed [EMUL_W-1:0] emul_log_t;

endpackage

// File: rtl/vop_vtype_dec.sv
module vop_vtype_dec
   import vop_legal_pkg::*;
(
   input  logic [CODE_W-1:0] lmul_code,
   input  logic [CODE_W-1:0] sew_code,
   output logic              lmul_rsvd,
   output logic              sew_rsvd,
   output emul_log_t         lmul_log,
   output logic [2:0]        sew_log
);

   always_comb begin
      lmul_rsvd = 1'b0;
      unique case (lmul_code)
         3'b000:  lmul_log = 4'sd0;
         3'b001:  lmul_log = 4'sd1;
         3'b010:  lmul_log = 4'sd2;
         3'b011:  lmul_log = 4'sd3;
         3'b111:  lmul_log = -4'sd1;
         3'b110:  lmul_log = -4'sd2;
         3'b101:  lmul_log = -4'sd3;
         default: begin
            lmul_rsvd = 1'b1;
            lmul_log  = 4'sd0;
         end
      endcase
   end

   // Width codes with the top bit set would name widths above 64 bits.
   always_comb begin
      sew_rsvd = sew_code[2];
      sew_log  = {1'b0, sew_code[1:0]} + 3'd3;
   end

endmodule

// File: rtl/vop_emul_calc.sv
module vop_emul_calc
   import vop_legal_pkg::*;
#(
   parameter int VLEN_LOG = 7
)(
   input  emul_log_t          lmul_log,
   input  logic [2:0]         sew_log,
   input  logic [EEWC_W-1:0]  eew_code,
   input  logic               own_eew,
   input  logic               widen_dst,
   input  logic               used,
   input  logic               eg_en,
   input  logic [2:0]         egs_log,
   input  logic [REG_W-1:0]   reg_idx,
   output emul_log_t          emul_log,
   output logic               range_err,
   output logic               align_err
);

   localparam logic signed [5:0] MAX_LOG = 6'sd3;
   localparam logic signed [5:0] MIN_LOG = -6'sd3;
   localparam logic signed [5:0] VLOG_S  = 6'(VLEN_LOG);

   logic signed [5:0] lmul_s;
   logic signed [5:0] sew_s;
   logic signed [5:0] eew_s;
   logic signed [5:0] emul_raw;
   logic signed [5:0] eg_regs;
   logic signed [5:0] need_emul;
   logic signed [5:0] need_grp;
   logic signed [5:0] need_log;
   logic [1:0]        need_clip;
   logic [REG_W-1:0]  low_mask;

   always_comb begin
      lmul_s = {{2{lmul_log[EMUL_W-1]}}, lmul_log};
      sew_s  = {3'b000, sew_log};
      eew_s  = {4'b0000, eew_code} + 6'sd3;
      if (own_eew)
         emul_raw = lmul_s + eew_s - sew_s;
      else if (widen_dst)
         emul_raw = lmul_s + 6'sd1;
      else
         emul_raw = lmul_s;
   end

   // Registers covered by one element group of SEW * 2^egs bits.
   always_comb begin
      eg_regs = sew_s + {3'b000, egs_log} - VLOG_S;
   end

   always_comb begin
      range_err = used && ((emul_raw > MAX_LOG) || (emul_raw < MIN_LOG) ||
                           (eg_en && (eg_regs > MAX_LOG)));
   end

   always_comb begin
      need_emul = (emul_raw > 6'sd0) ? emul_raw : 6'sd0;
      need_grp  = (eg_en && (eg_regs > 6'sd0)) ? eg_regs : 6'sd0;
      need_log  = (need_grp > need_emul) ? need_grp : need_emul;
      need_clip = (need_log > MAX_LOG) ? 2'd3 : need_log[1:0];
      low_mask  = (REG_W'(1) << need_clip) - REG_W'(1);
      align_err = used && ((reg_idx & low_mask) != '0);
   end

   always_comb begin
      emul_log = used ? emul_raw[EMUL_W-1:0] : '0;
   end

endmodule

// File: rtl/vop_eg_chk.sv
module vop_eg_chk #(
   parameter int VL_W = 16
)(
   input  logic            eg_en,
   input  logic [2:0]      egs_log,
   input  logic [VL_W-1:0] vl,
   input  logic [VL_W-1:0] vstart,
   output logic            eg_err
);

   logic [VL_W-1:0] rem_mask;

   always_comb begin
      rem_mask = (VL_W'(1) << egs_log) - VL_W'(1);
      eg_err   = eg_en && (((vl & rem_mask) != '0) || ((vstart & rem_mask) != '0));
   end

endmodule

// File: rtl/vop_legal_chk.sv
module vop_legal_chk
   import vop_legal_pkg::*;
#(
   parameter int NOPS = 3,
   parameter int VLEN = 128,
   parameter int VL_W = 16
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic [2:0]             in_lmul_code,
   input  logic [2:0]             in_sew_code,
   input  logic                   in_widen,
   input  logic [NOPS-1:0]        in_op_used,
   input  logic [NOPS-1:0]        in_op_own_eew,
   input  logic [2*NOPS-1:0]      in_op_eew_code,
   input  logic [5*NOPS-1:0]      in_op_reg,
   input  logic                   in_eg_en,
   input  logic [2:0]             in_egs_log,
   input  logic [VL_W-1:0]        in_vl,
   input  logic [VL_W-1:0]        in_vstart,
   output logic                   out_valid,
   output logic [4*NOPS-1:0]      out_emul_log,
   output logic                   out_illegal,
   output logic [2:0]             out_cause
);

   localparam int VLEN_LOG = $clog2(VLEN);
   localparam int EMUL_ALL = EMUL_W * NOPS;

   if (NOPS < 1 || NOPS > 4) begin : g_bad_nops
      $error("vop_legal_chk: NOPS must lie in 1..4");
   end
   if (VLEN < 64 || (1 << VLEN_LOG) != VLEN) begin : g_bad_vlen
      $error("vop_legal_chk: VLEN must be a power of two of at least 64");
   end
   if (VL_W < 8 || VL_W > 32) begin : g_bad_vlw
      $error("vop_legal_chk: VL_W must lie in 8..32");
   end

   logic        lmul_rsvd;
   logic        sew_rsvd;
   emul_log_t   lmul_log;
   logic [2:0]  sew_log;

   vop_vtype_dec u_dec (
      .lmul_code (in_lmul_code),
      .sew_code  (in_sew_code),
      .lmul_rsvd (lmul_rsvd),
      .sew_rsvd  (sew_rsvd),
      .lmul_log  (lmul_log),
      .sew_log   (sew_log)
   );

   logic [NOPS-1:0]     range_v;
   logic [NOPS-1:0]     align_v;
   logic [EMUL_ALL-1:0] emul_c;

   for (genvar i = 0; i < NOPS; i++) begin : g_op
      emul_log_t op_emul;
      logic      op_widen;

      if (i == 0) begin : g_dst
         assign op_widen = in_widen;
      end else begin : g_src
         assign op_widen = 1'b0;
      end

      vop_emul_calc #(.VLEN_LOG(VLEN_LOG)) u_calc (
         .lmul_log  (lmul_log),
         .sew_log   (sew_log),
         .eew_code  (in_op_eew_code[i*EEWC_W +: EEWC_W]),
         .own_eew   (in_op_own_eew[i]),
         .widen_dst (op_widen),
         .used      (in_op_used[i]),
         .eg_en     (in_eg_en),
         .egs_log   (in_egs_log),
         .reg_idx   (in_op_reg[i*REG_W +: REG_W]),
         .emul_log  (op_emul),
         .range_err (range_v[i]),
         .align_err (align_v[i])
      );

      assign emul_c[i*EMUL_W +: EMUL_W] = op_emul;
   end

   logic eg_err;

   vop_eg_chk #(.VL_W(VL_W)) u_eg (
      .eg_en   (in_eg_en),
      .egs_log (in_egs_log),
      .vl      (in_vl),
      .vstart  (in_vstart),
      .eg_err  (eg_err)
   );

   vop_cause_e          cause_c;
   logic                illegal_c;
   logic [EMUL_ALL-1:0] emul_sel;

   always_comb begin
      if (lmul_rsvd)        cause_c = CAUSE_VLMUL;
      else if (sew_rsvd)    cause_c = CAUSE_SEW;
      else if (|range_v)    cause_c = CAUSE_EMUL;
      else if (|align_v)    cause_c = CAUSE_ALIGN;
      else if (eg_err)      cause_c = CAUSE_EGRP;
      else                  cause_c = CAUSE_NONE;
      illegal_c = lmul_rsvd | sew_rsvd | (|range_v) | (|align_v) | eg_err;
      emul_sel  = (lmul_rsvd | sew_rsvd) ? '0 : emul_c;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid    <= 1'b0;
         out_illegal  <= 1'b0;
         out_cause    <= 3'd0;
         out_emul_log <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_illegal  <= illegal_c;
            out_cause    <= cause_c;
            out_emul_log <= emul_sel;
         end
      end
   end

endmodule

// File: rtl/vop_legal_sva.sv
module vop_legal_sva #(
   parameter int NOPS = 3,
   parameter int VLEN = 128,
   parameter int VL_W = 16
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic [2:0]             in_lmul_code,
   input  logic [2:0]             in_sew_code,
   input  logic                   in_widen,
   input  logic [NOPS-1:0]        in_op_used,
   input  logic [NOPS-1:0]        in_op_own_eew,
   input  logic [2*NOPS-1:0]      in_op_eew_code,
   input  logic [5*NOPS-1:0]      in_op_reg,
   input  logic                   in_eg_en,
   input  logic [2:0]             in_egs_log,
   input  logic [VL_W-1:0]        in_vl,
   input  logic [VL_W-1:0]        in_vstart,
   input  logic                   out_valid,
   input  logic [4*NOPS-1:0]      out_emul_log,
   input  logic                   out_illegal,
   input  logic [2:0]             out_cause
);

   logic [VL_W-1:0] grp_mask;
   assign grp_mask = (VL_W'(1) << in_egs_log) - VL_W'(1);

   AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);                                              // R12
   AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);                                            // R12
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_cause) && $stable(out_illegal)));          // R12
   AST_RSVD_LMUL: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_lmul_code == 3'b100) |=> (out_illegal && out_cause == 3'd1)); // R2
   AST_RSVD_SEW: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_lmul_code != 3'b100 && in_sew_code[2]) |=> (out_cause == 3'd2)); // R3
   AST_EGRP_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_eg_en && ((in_vl & grp_mask) != '0)) |=> out_illegal); // R8
   AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_illegal == (out_cause != 3'd0)));                  // R11

   for (genvar i = 0; i < NOPS; i++) begin : g_chk
      AST_EMUL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && !out_illegal) |->
            ($signed(out_emul_log[i*4 +: 4]) <= 4'sd3 &&
             $signed(out_emul_log[i*4 +: 4]) >= -4'sd3));                   // R6
      AST_REG_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && !out_illegal && $past(in_op_used[i]) &&
          $signed(out_emul_log[i*4 +: 4]) > 4'sd0) |->
            (($past(in_op_reg[i*5 +: 5]) &
              ((5'd1 << out_emul_log[i*4 +: 2]) - 5'd1)) == 5'd0));         // R7
   end

endmodule

bind vop_legal_chk vop_legal_sva #(.NOPS(NOPS), .VLEN(VLEN), .VL_W(VL_W)) u_sva (.*);

// File: tb/sim_vop_legal_chk.sv
`timescale 1ns/1ps
module sim_vop_legal_chk;

   localparam int NOPS = 3;
   localparam int VLEN = 128;
   localparam int VL_W = 16;
   localparam int WATCHDOG = 150000;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                in_valid = 1'b0;
   logic [2:0]          in_lmul_code = '0;
   logic [2:0]          in_sew_code = '0;
   logic                in_widen = 1'b0;
   logic [NOPS-1:0]     in_op_used = '0;
   logic [NOPS-1:0]     in_op_own_eew = '0;
   logic [2*NOPS-1:0]   in_op_eew_code = '0;
   logic [5*NOPS-1:0]   in_op_reg = '0;
   logic                in_eg_en = 1'b0;
   logic [2:0]          in_egs_log = '0;
   logic [VL_W-1:0]     in_vl = '0;
   logic [VL_W-1:0]     in_vstart = '0;
   logic                out_valid;
   logic [4*NOPS-1:0]   out_emul_log;
   logic                out_illegal;
   logic [2:0]          out_cause;

   always #2.5 clk = ~clk;

   vop_legal_chk #(.NOPS(NOPS), .VLEN(VLEN), .VL_W(VL_W)) u0 (.*);

   int n_chk = 0;
   int n_fail = 0;
   int exp_cause;
   int exp_emul [NOPS];

   function automatic int lg2(input int v);
      int n = 0;
      while (v > 1) begin v = v >> 1; n++; end
      return n;
   endfunction

   // Reference: multipliers kept as counts of 1/64 register.
   task automatic model();
      int lmul64, sew, eew, e64, regs, nal, egw, grp, egs;
      bit rng, mis;
      rng = 0; mis = 0;
      for (int i = 0; i < NOPS; i++) exp_emul[i] = 0;
      case (in_lmul_code)
         3'b000: lmul64 = 64;   3'b001: lmul64 = 128;
         3'b010: lmul64 = 256;  3'b011: lmul64 = 512;
         3'b111: lmul64 = 32;   3'b110: lmul64 = 16;
         3'b101: lmul64 = 8;    default: lmul64 = 0;
      endcase
      if (lmul64 == 0) begin exp_cause = 1; return; end
      if (in_sew_code >= 3'd4) begin exp_cause = 2; return; end
      sew = 8 << in_sew_code;
      egs = 1 << in_egs_log;
      for (int i = 0; i < NOPS; i++) begin
         if (!in_op_used[i]) continue;
         if (in_op_own_eew[i]) eew = 8 << in_op_eew_code[i*2 +: 2];
         else if (i == 0 && in_widen) eew = 2 * sew;
         else eew = sew;
         e64 = eew * lmul64 / sew;
         exp_emul[i] = lg2(e64) - 6;
         if (e64 < 8 || e64 > 512) rng = 1;
         regs = e64 / 64;
         nal = (regs < 1) ? 1 : regs;
         if (in_eg_en) begin
            egw = sew * egs;
            grp = egw / VLEN;
            if (grp > 8) rng = 1;
            if (grp > nal) nal = grp;
         end
         if (nal <= 8 && (in_op_reg[i*5 +: 5] % nal) != 0) mis = 1;
      end
      if (rng) exp_cause = 3;
      else if (mis) exp_cause = 4;
      else if (in_eg_en && ((in_vl % egs) != 0 || (in_vstart % egs) != 0)) exp_cause = 5;
      else exp_cause = 0;
   endtask

   function automatic string tag_of(input int c);
      case (c)
         1: return "R2";  2: return "R3";  3: return "R6";
         4: return "R7";  5: return "R8";  default: return "R1";
      endcase
   endfunction

   task automatic compare(input string tag);
      bit bad;
      bad = (out_valid !== 1'b1) || (out_cause !== 3'(exp_cause)) ||
            (out_illegal !== (exp_cause != 0));
      for (int i = 0; i < NOPS; i++)
         if ($signed(out_emul_log[i*4 +: 4]) != exp_emul[i]) bad = 1;
      n_chk++;
      if (bad) begin
         n_fail++;
         $display("FAIL %s: cause=%0d exp=%0d illegal=%0b emul=%0d/%0d/%0d exp=%0d/%0d/%0d valid=%0b",
                  tag, out_cause, exp_cause, out_illegal,
                  $signed(out_emul_log[3:0]), $signed(out_emul_log[7:4]),
                  $signed(out_emul_log[11:8]),
                  exp_emul[0], exp_emul[1], exp_emul[2], out_valid);
      end
   endtask

   // Entered just after a falling edge; result sampled on the next one.
   task automatic run(input string tag);
      model();
      in_valid = 1'b1;
      @(negedge clk);
      compare((tag == "") ? tag_of(exp_cause) : tag);
   endtask

   task automatic plain();
      in_lmul_code = 3'b000; in_sew_code = 3'b010; in_widen = 0;
      in_op_used = 3'b001; in_op_own_eew = '0; in_op_eew_code = '0;
      in_op_reg = '0; in_eg_en = 0; in_egs_log = 0; in_vl = 0; in_vstart = 0;
   endtask

   task automatic expect_direct(input string tag, input int c, input int e0);
      n_chk++;
      if (out_cause !== 3'(c) || $signed(out_emul_log[3:0]) != e0) begin
         n_fail++;
         $display("FAIL %s: cause=%0d exp=%0d emul0=%0d exp=%0d",
                  tag, out_cause, c, $signed(out_emul_log[3:0]), e0);
      end
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [2:0] snap_c;
      logic [4*NOPS-1:0] snap_e;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R12: reset state
      n_chk++;
      if (out_valid !== 0 || out_illegal !== 0 || out_cause !== 0 || out_emul_log !== '0) begin
         n_fail++;
         $display("FAIL R12: reset outputs valid=%0b cause=%0d, expected all zero", out_valid, out_cause);
      end
      rst_n = 1'b1;
      @(negedge clk);

      // R4: own width 8 at SEW 32, LMUL 1 -> 1/4 (log -2)
      plain(); in_op_own_eew = 3'b001; in_op_eew_code = 6'b000000;
      run("R4"); expect_direct("R4", 0, -2);
      // R5: widen LMUL 2 -> 4 registers, v4 legal, v2 misaligned
      plain(); in_lmul_code = 3'b001; in_widen = 1; in_op_reg[4:0] = 5'd4;
      run("R5"); expect_direct("R5", 0, 2);
      in_op_reg[4:0] = 5'd2;
      run("R5"); expect_direct("R5", 4, 2);
      // R9: 8 x 64-bit group = 512 bits = 4 registers
      plain(); in_sew_code = 3'b011; in_eg_en = 1; in_egs_log = 3; in_vl = 8;
      in_op_reg[4:0] = 5'd2; run("R9"); expect_direct("R9", 4, 0);
      in_op_reg[4:0] = 5'd4; run("R9"); expect_direct("R9", 0, 0);
      in_egs_log = 7; in_vl = 128; in_op_reg[4:0] = 5'd0;
      run("R9"); expect_direct("R9", 3, 0);
      // R10: unused operand with extreme settings is ignored
      plain(); in_lmul_code = 3'b011; in_sew_code = 3'b000;
      in_op_used = 3'b001; in_op_own_eew = 3'b100; in_op_eew_code = 6'b110000;
      in_op_reg = {5'd3, 5'd1, 5'd8};
      run("R10");
      // R11: priority ordering
      plain(); in_lmul_code = 3'b100; in_sew_code = 3'b111; run("R11");
      plain(); in_sew_code = 3'b101; in_lmul_code = 3'b011; in_op_reg[4:0] = 5'd3; run("R11");
      plain(); in_lmul_code = 3'b011; in_widen = 1; in_op_used = 3'b011;
      in_op_reg = {5'd0, 5'd1, 5'd0}; run("R11");
      plain(); in_lmul_code = 3'b001; in_op_reg[4:0] = 5'd1; in_eg_en = 1; in_egs_log = 2;
      in_vl = 3; run("R11");

      // Sweep 1: every vtype code, widening, own widths, low register numbers
      for (int lc = 0; lc < 8; lc++)
         for (int sc = 0; sc < 8; sc++)
            for (int w = 0; w < 2; w++)
               for (int o0 = 0; o0 < 2; o0++)
                  for (int ec = 0; ec < 4; ec++)
                     for (int u2 = 0; u2 < 2; u2++)
                        for (int d = 0; d < 8; d++) begin
                           in_lmul_code = 3'(lc); in_sew_code = 3'(sc); in_widen = w[0];
                           in_op_used = {u2[0], 1'b1, 1'b1};
                           in_op_own_eew = {1'b1, 1'b0, o0[0]};
                           in_op_eew_code = {2'd3, 2'd0, 2'(ec)};
                           in_op_reg = {5'((d * 3) % 32), 5'(d + 2), 5'(d)};
                           in_eg_en = 0; in_egs_log = 3'd2; in_vl = 5; in_vstart = 3;
                           run("");
                        end

      // Sweep 2: element groups against length, start and alignment (R8, R9)
      for (int sc = 0; sc < 4; sc++)
         for (int g = 0; g < 8; g++)
            for (int v = 0; v < 20; v++)
               for (int s = 0; s < 4; s++)
                  for (int d = 0; d < 8; d++) begin
                     plain();
                     in_sew_code = 3'(sc); in_eg_en = 1; in_egs_log = 3'(g);
                     in_vl = VL_W'(v); in_vstart = VL_W'((s == 0) ? 0 : (1 << s));
                     in_op_reg[4:0] = 5'(d);
                     run("");
                  end

      // R12: hold without a request
      snap_c = out_cause; snap_e = out_emul_log;
      in_valid = 1'b0; in_lmul_code = 3'b100;
      @(negedge clk);
      n_chk++;
      if (out_valid !== 0 || out_cause !== snap_c || out_emul_log !== snap_e) begin
         n_fail++;
         $display("FAIL R12: hold valid=%0b cause=%0d, expected valid=0 cause=%0d",
                  out_valid, out_cause, snap_c);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule